// File: doc/BRIEF.md
# Multi-Memory Built-In Self-Test Controller

This block runs self-tests on three on-chip memories: a shared RAM, a scratchpad RAM and a read-only microcode store. A host selects any combination of the three with a target mask and pulses start. The selected memories are then tested in parallel. Each RAM gets a full write pass followed by a full read-and-compare pass using one of four data patterns. The ROM is read end to end through a multiple-input signature register, and the result is compared with an expected signature that the host supplies.

While a run is in flight the controller holds busy and refuses any further start. A cancel aborts every engine and returns the controller to idle without a completion pulse, and the results are then marked invalid. A normal completion raises done for one cycle, drops busy and presents per-memory pass bits. For each RAM it also presents the first address that miscompared. The memories themselves are outside the block: each one is driven through a plain synchronous port with a one-cycle read latency.

Top module: `mbist_ctrl`

## Requirements
- R1: After reset, busy, done, res_valid and pass are all zero, and no memory write or read strobe is asserted.
- R2: When the controller is idle, a start with a non-zero tgt_sel and no cancel is accepted, and busy is high from the next cycle. A start with tgt_sel equal to zero is ignored.
- R3: tgt_sel bit 0 selects the shared RAM, bit 1 the scratchpad RAM and bit 2 the ROM. All selected memories are tested concurrently, and an unselected memory sees no strobe during the run.
- R4: A start that arrives while busy is high is ignored. The running test keeps its original target set and pattern.
- R5: A cancel while busy aborts all engines. From the next cycle busy, res_valid and every memory strobe are low, and done is not raised for that run.
- R6: On normal completion done is high for exactly one cycle. In that same cycle busy is low and res_valid is high.
- R7: pat_sel is captured at start. It is encoded as 0 = checkerboard, where bit i of the word at address a is 1 when i+a is even; 1 = walking one, where only bit (a mod DW) is set; 2 = walking zero, the bitwise inverse of walking one; and 3 = counting, where the data is the address zero-extended or truncated to DW.
- R8: A RAM test writes the pattern to every address in ascending order, then reads every address in ascending order and compares the data. The memory's pass bit is 1 only if no word miscompared.
- R9: When a RAM fails, its fail-address output holds the lowest address that miscompared.
- R10: The ROM test starts from signature 0. For each word w, read in ascending address order, it computes s = {s[DW-2:0],0} ^ (s[DW-1] ? ROM_POLY : 0) ^ w, with ROM_POLY defaulting to 8'h1D. The pass bit is set when the final s equals rom_sig_exp as captured at start.
- R11: pass bit 0 reports the shared RAM, bit 1 the scratchpad and bit 2 the ROM. The pass bit of an unselected memory is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_sel | input | 3 | Target mask: shared, scratchpad, ROM |
| pat_sel | input | 2 | RAM data pattern code |
| start | input | 1 | Start request |
| cancel | input | 1 | Abort the running test |
| rom_sig_exp | input | DW | Expected ROM signature |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion pulse |
| res_valid | output | 1 | Results from the last run are valid |
| pass | output | 3 | Per-memory pass flags |
| shr_fail_addr | output | SHR_AW | First failing shared RAM address |
| scr_fail_addr | output | SCR_AW | First failing scratchpad address |
| shr_addr | output | SHR_AW | Shared RAM address |
| shr_wdata | output | DW | Shared RAM write data |
| shr_we | output | 1 | Shared RAM write strobe |
| shr_re | output | 1 | Shared RAM read strobe |
| shr_rdata | input | DW | Shared RAM read data, one cycle after shr_re |
| scr_addr | output | SCR_AW | Scratchpad address |
| scr_wdata | output | DW | Scratchpad write data |
| scr_we | output | 1 | Scratchpad write strobe |
| scr_re | output | 1 | Scratchpad read strobe |
| scr_rdata | input | DW | Scratchpad read data, one cycle after scr_re |
| rom_addr | output | ROM_AW | ROM address |
| rom_re | output | 1 | ROM read strobe |
| rom_rdata | input | DW | ROM read data, one cycle after rom_re |

## Verification
A wrong engine state shows at the memory ports as soon as it occurs. A stray strobe on an unselected memory, strobes after a cancel, or a write during the read pass are all visible within one cycle. Errors in the comparison or capture path only surface at done, as a wrong pass bit or a wrong first-fail address. For that reason, stuck-at-one faults are swept across every address of both RAMs under all four patterns, so that each detected or undetected case lands on a predicted address. Interlock errors appear as an extra memory's strobes or pass bit in the run that received the ignored start.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [1:0] {
    PAT_CHECKER = 2'd0,
    PAT_WALK1   = 2'd1,
    PAT_WALK0   = 2'd2,
    PAT_COUNT   = 2'd3
  } pat_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WR    = 3'd1,
    ST_RD    = 3'd2,
    ST_DRAIN = 3'd3,
    ST_FIN   = 3'd4
  } eng_st_e;

  // Pattern word for address a; caller truncates to its data width (dw < 64).
  function automatic logic [63:0] pat_word(pat_e p, logic [31:0] a, int dw);
    logic [63:0] w;
    int unsigned k;
    w = '0;
    k = a % dw;
    case (p)
      PAT_CHECKER: for (int i = 0; i < 64; i++) w[i] = ~(a[0] ^ (i % 2 == 1));
      PAT_WALK1:   w[k] = 1'b1;
      PAT_WALK0:   begin w = '1; w[k] = 1'b0; end
      default:     w = {32'b0, a};
    endcase
    return w;
  endfunction

  // One step of the signature register, width dw (dw < 64).
  function automatic logic [63:0] misr_next(logic [63:0] s, logic [63:0] d,
                                            logic [63:0] poly, int dw);
    logic [63:0] r;
    r = (s << 1) ^ (s[dw-1] ? poly : 64'd0) ^ d;
    return r & ((64'd1 << dw) - 64'd1);
  endfunction

endpackage

// File: rtl/mbist_ram_eng.sv
module mbist_ram_eng
  import mbist_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          abort,
  input  pat_e          pat,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          fin,
  output logic          fail,
  output logic [AW-1:0] fail_addr
);
  localparam logic [AW-1:0] LAST = '1;

  eng_st_e       st;
  logic [AW-1:0] addr;
  logic [AW-1:0] cmp_addr;
  logic          cmp_vld;
  pat_e          pat_q;
  logic [DW-1:0] exp_word;
  logic          miscmp;

  assign exp_word = DW'(pat_word(pat_q, 32'(cmp_addr), DW));
  assign miscmp   = cmp_vld && (mem_rdata != exp_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      addr      <= '0;
      cmp_addr  <= '0;
      cmp_vld   <= 1'b0;
      pat_q     <= PAT_CHECKER;
      fail      <= 1'b0;
      fail_addr <= '0;
    end else if (abort) begin
      st      <= ST_IDLE;
      cmp_vld <= 1'b0;
      addr    <= '0;
    end else begin
      if (miscmp && !fail) begin
        fail      <= 1'b1;
        fail_addr <= cmp_addr;
      end
      case (st)
        ST_IDLE, ST_FIN: if (go) begin
          st        <= ST_WR;
          addr      <= '0;
          pat_q     <= pat;
          fail      <= 1'b0;
          fail_addr <= '0;
        end
        ST_WR: begin
          addr <= addr + 1'b1;
          if (addr == LAST) st <= ST_RD;
        end
        ST_RD: begin
          cmp_vld  <= 1'b1;
          cmp_addr <= addr;
          addr     <= addr + 1'b1;
          if (addr == LAST) st <= ST_DRAIN;
        end
        ST_DRAIN: begin
          cmp_vld <= 1'b0;
          st      <= ST_FIN;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr  = addr;
  assign mem_wdata = DW'(pat_word(pat_q, 32'(addr), DW));
  assign mem_we    = (st == ST_WR);
  assign mem_re    = (st == ST_RD);
  assign fin       = (st == ST_FIN);
endmodule

// File: rtl/mbist_rom_eng.sv
module mbist_rom_eng
  import mbist_pkg::*;
#(
  parameter int            AW   = 4,
  parameter int            DW   = 8,
  parameter logic [DW-1:0] POLY = 8'h1D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          abort,
  input  logic [DW-1:0] sig_exp,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          fin,
  output logic          fail
);
  localparam logic [AW-1:0] LAST = '1;

  eng_st_e       st;
  logic [AW-1:0] addr;
  logic          cmp_vld;
  logic [DW-1:0] sig;
  logic [DW-1:0] exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      addr    <= '0;
      cmp_vld <= 1'b0;
      sig     <= '0;
      exp_q   <= '0;
    end else if (abort) begin
      st      <= ST_IDLE;
      cmp_vld <= 1'b0;
      addr    <= '0;
    end else begin
      if (cmp_vld)
        sig <= DW'(misr_next(64'(sig), 64'(mem_rdata), 64'(POLY), DW));
      case (st)
        ST_IDLE, ST_FIN: if (go) begin
          st    <= ST_RD;
          addr  <= '0;
          sig   <= '0;
          exp_q <= sig_exp;
        end
        ST_RD: begin
          cmp_vld <= 1'b1;
          addr    <= addr + 1'b1;
          if (addr == LAST) st <= ST_DRAIN;
        end
        ST_DRAIN: begin
          cmp_vld <= 1'b0;
          st      <= ST_FIN;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr = addr;
  assign mem_re   = (st == ST_RD);
  assign fin      = (st == ST_FIN);
  assign fail     = (sig != exp_q);
endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
  import mbist_pkg::*;
#(
  parameter int            DW       = 8,
  parameter int            SHR_AW   = 4,
  parameter int            SCR_AW   = 3,
  parameter int            ROM_AW   = 4,
  parameter logic [DW-1:0] ROM_POLY = 8'h1D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        tgt_sel,
  input  logic [1:0]        pat_sel,
  input  logic              start,
  input  logic              cancel,
  input  logic [DW-1:0]     rom_sig_exp,
  output logic              busy,
  output logic              done,
  output logic              res_valid,
  output logic [2:0]        pass,
  output logic [SHR_AW-1:0] shr_fail_addr,
  output logic [SCR_AW-1:0] scr_fail_addr,
  output logic [SHR_AW-1:0] shr_addr,
  output logic [DW-1:0]     shr_wdata,
  output logic              shr_we,
  output logic              shr_re,
  input  logic [DW-1:0]     shr_rdata,
  output logic [SCR_AW-1:0] scr_addr,
  output logic [DW-1:0]     scr_wdata,
  output logic              scr_we,
  output logic              scr_re,
  input  logic [DW-1:0]     scr_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_re,
  input  logic [DW-1:0]     rom_rdata
);
  localparam int NTGT = 3;

  // Named control events, observed by the bound checker.
  logic            accept;
  logic            abort;
  logic            all_fin;
  logic [NTGT-1:0] sel_q;
  logic [NTGT-1:0] go_vec;
  logic [NTGT-1:0] fin_vec;
  logic [NTGT-1:0] fail_vec;

  assign accept  = start && !busy && !cancel && (tgt_sel != '0);
  assign abort   = cancel && busy;
  assign go_vec  = accept ? tgt_sel : '0;
  assign all_fin = &(~sel_q | fin_vec);

  mbist_ram_eng #(.AW(SHR_AW), .DW(DW)) u_shr (
    .clk(clk), .rst_n(rst_n), .go(go_vec[0]), .abort(abort), .pat(pat_e'(pat_sel)),
    .mem_addr(shr_addr), .mem_wdata(shr_wdata), .mem_we(shr_we), .mem_re(shr_re),
    .mem_rdata(shr_rdata), .fin(fin_vec[0]), .fail(fail_vec[0]),
    .fail_addr(shr_fail_addr)
  );

  mbist_ram_eng #(.AW(SCR_AW), .DW(DW)) u_scr (
    .clk(clk), .rst_n(rst_n), .go(go_vec[1]), .abort(abort), .pat(pat_e'(pat_sel)),
    .mem_addr(scr_addr), .mem_wdata(scr_wdata), .mem_we(scr_we), .mem_re(scr_re),
    .mem_rdata(scr_rdata), .fin(fin_vec[1]), .fail(fail_vec[1]),
    .fail_addr(scr_fail_addr)
  );

  mbist_rom_eng #(.AW(ROM_AW), .DW(DW), .POLY(ROM_POLY)) u_rom (
    .clk(clk), .rst_n(rst_n), .go(go_vec[2]), .abort(abort), .sig_exp(rom_sig_exp),
    .mem_addr(rom_addr), .mem_re(rom_re), .mem_rdata(rom_rdata),
    .fin(fin_vec[2]), .fail(fail_vec[2])
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      res_valid <= 1'b0;
      pass      <= '0;
      sel_q     <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy      <= 1'b0;
        res_valid <= 1'b0;
        pass      <= '0;
      end else if (accept) begin
        busy      <= 1'b1;
        sel_q     <= tgt_sel;
        res_valid <= 1'b0;
        pass      <= '0;
      end else if (busy && all_fin) begin
        busy      <= 1'b0;
        done      <= 1'b1;
        res_valid <= 1'b1;
        pass      <= sel_q & ~fail_vec;
      end
    end
  end
endmodule

// File: rtl/mbist_ctrl_chk.sv
module mbist_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       cancel,
  input logic [2:0] tgt_sel,
  input logic       busy,
  input logic       done,
  input logic       res_valid,
  input logic [2:0] pass,
  input logic [2:0] sel_q,
  input logic       accept,
  input logic       abort,
  input logic       shr_we,
  input logic       shr_re,
  input logic       scr_we,
  input logic       scr_re,
  input logic       rom_re
);
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  p_zero_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && tgt_sel == 3'b000) |=> !busy);
  p_unsel_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((sel_q[0] || (!shr_we && !shr_re)) && (sel_q[1] || (!scr_we && !scr_re))
              && (sel_q[2] || !rom_re)));
  p_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !cancel) |=> $stable(sel_q));
  p_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !done && !res_valid && !shr_we && !shr_re && !scr_we && !scr_re && !rom_re));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && res_valid));
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(shr_we && shr_re) && !(scr_we && scr_re));
  p_pass_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((pass & ~sel_q) == 3'b000));
endmodule

bind mbist_ctrl mbist_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cancel(cancel), .tgt_sel(tgt_sel),
  .busy(busy), .done(done), .res_valid(res_valid), .pass(pass), .sel_q(sel_q),
  .accept(accept), .abort(abort), .shr_we(shr_we), .shr_re(shr_re),
  .scr_we(scr_we), .scr_re(scr_re), .rom_re(rom_re)
);

// File: tb/mbist_ctrl_test.sv
module mbist_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] tgt_sel = '0;
  logic [1:0] pat_sel = '0;
  logic       start = 1'b0;
  logic       cancel = 1'b0;
  logic [7:0] rom_sig_exp = '0;
  logic       busy, done, res_valid;
  logic [2:0] pass;
  logic [3:0] shr_fail_addr, shr_addr, rom_addr;
  logic [2:0] scr_fail_addr, scr_addr;
  logic [7:0] shr_wdata, shr_rdata, scr_wdata, scr_rdata, rom_rdata;
  logic       shr_we, shr_re, scr_we, scr_re, rom_re;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] shr_mem [16];
  logic [7:0] scr_mem [8];
  logic [7:0] rom_mem [16];
  logic [7:0] shr_sa1 [16];
  logic [7:0] scr_sa1 [8];
  logic       cnt_clr = 1'b0;
  int         shr_cnt = 0, scr_cnt = 0, rom_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbist_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tgt_sel(tgt_sel), .pat_sel(pat_sel), .start(start),
    .cancel(cancel), .rom_sig_exp(rom_sig_exp), .busy(busy), .done(done),
    .res_valid(res_valid), .pass(pass), .shr_fail_addr(shr_fail_addr),
    .scr_fail_addr(scr_fail_addr), .shr_addr(shr_addr), .shr_wdata(shr_wdata),
    .shr_we(shr_we), .shr_re(shr_re), .shr_rdata(shr_rdata), .scr_addr(scr_addr),
    .scr_wdata(scr_wdata), .scr_we(scr_we), .scr_re(scr_re), .scr_rdata(scr_rdata),
    .rom_addr(rom_addr), .rom_re(rom_re), .rom_rdata(rom_rdata)
  );

  // Memory models: synchronous, one-cycle read, stuck-at-one faults on read.
  always @(posedge clk) begin
    if (shr_we) shr_mem[shr_addr] <= shr_wdata;
    if (shr_re) shr_rdata <= shr_mem[shr_addr] | shr_sa1[shr_addr];
    if (scr_we) scr_mem[scr_addr] <= scr_wdata;
    if (scr_re) scr_rdata <= scr_mem[scr_addr] | scr_sa1[scr_addr];
    if (rom_re) rom_rdata <= rom_mem[rom_addr];
  end

  always @(posedge clk) begin
    if (cnt_clr) begin
      shr_cnt <= 0; scr_cnt <= 0; rom_cnt <= 0;
    end else begin
      if (shr_we || shr_re) shr_cnt <= shr_cnt + 1;
      if (scr_we || scr_re) scr_cnt <= scr_cnt + 1;
      if (rom_re) rom_cnt <= rom_cnt + 1;
    end
  end

  function automatic logic [7:0] bword(input int p, input int a);
    case (p)
      0:       bword = (a % 2 == 0) ? 8'h55 : 8'hAA;
      1:       bword = 8'h01 << (a % 8);
      2:       bword = ~(8'h01 << (a % 8));
      default: bword = 8'(a);
    endcase
  endfunction

  function automatic logic [7:0] rom_sig();
    logic [7:0] s = 8'h00;
    for (int a = 0; a < 16; a++)
      s = {s[6:0], 1'b0} ^ (s[7] ? 8'h1D : 8'h00) ^ rom_mem[a];
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Predict first failing address (-1 if none) for a RAM with stuck-at-one masks.
  function automatic int first_fail_shr(input int p);
    for (int a = 0; a < 16; a++)
      if ((bword(p, a) & shr_sa1[a]) != shr_sa1[a]) return a;
    return -1;
  endfunction

  function automatic int first_fail_scr(input int p);
    for (int a = 0; a < 8; a++)
      if ((bword(p, a) & scr_sa1[a]) != scr_sa1[a]) return a;
    return -1;
  endfunction

  task automatic run(input logic [2:0] sel, input int p, input logic [7:0] sig);
    int wait_n = 0;
    int ffs = first_fail_shr(p);
    int ffc = first_fail_scr(p);
    logic [2:0] ep;
    ep[0] = sel[0] && (ffs < 0);
    ep[1] = sel[1] && (ffc < 0);
    ep[2] = sel[2] && (sig == rom_sig());
    @(negedge clk);
    tgt_sel = sel; pat_sel = 2'(p); rom_sig_exp = sig; start = 1'b1; cnt_clr = 1'b1;
    @(negedge clk);
    start = 1'b0; cnt_clr = 1'b0;
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    while (!done && wait_n < 200) begin
      @(negedge clk);
      wait_n++;
    end
    check(done == 1'b1, "R6 done seen", int'(done), 1);
    check(!busy && res_valid, "R6 busy low valid high", int'({busy, res_valid}), 1);
    check(pass == ep, "R8 R10 R11 pass bits", int'(pass), int'(ep));
    if (sel[0] && ffs >= 0) check(int'(shr_fail_addr) == ffs, "R9 shared fail addr", int'(shr_fail_addr), ffs);
    if (sel[1] && ffc >= 0) check(int'(scr_fail_addr) == ffc, "R9 scratch fail addr", int'(scr_fail_addr), ffc);
    check((sel[0] || shr_cnt == 0) && (sel[1] || scr_cnt == 0) && (sel[2] || rom_cnt == 0),
          "R3 unselected untouched", shr_cnt + scr_cnt + rom_cnt, 0);
    if (sel[0]) check(shr_cnt == 32, "R8 shared write+read count", shr_cnt, 32);
    @(negedge clk);
    check(done == 1'b0, "R6 done one cycle", int'(done), 0);
  endtask

  task automatic clear_faults();
    for (int a = 0; a < 16; a++) shr_sa1[a] = 8'h00;
    for (int a = 0; a < 8; a++) scr_sa1[a] = 8'h00;
  endtask

  initial begin
    clear_faults();
    for (int a = 0; a < 16; a++) rom_mem[a] = 8'(a * 29 + 7);
    repeat (3) @(negedge clk);
    check(!busy && !done && !res_valid && pass == 3'b000, "R1 reset outputs",
          int'({busy, done, res_valid, pass}), 0);
    check(!shr_we && !shr_re && !scr_we && !scr_re && !rom_re, "R1 reset strobes", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: zero mask ignored.
    tgt_sel = 3'b000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b0, "R2 zero mask ignored", int'(busy), 0);

    // R3 R7 R8: clean sweep of all patterns and target combinations.
    for (int p = 0; p < 4; p++)
      for (int s = 1; s < 8; s++) run(3'(s), p, rom_sig());

    // R7 R9: single stuck-at-one fault at every shared address.
    for (int p = 0; p < 4; p++)
      for (int fa = 0; fa < 16; fa++) begin
        clear_faults();
        shr_sa1[fa] = 8'h01 << ((fa * 3) % 8);
        run(3'b111, p, rom_sig());
      end
    // Scratchpad single faults.
    for (int p = 0; p < 4; p++)
      for (int fa = 0; fa < 8; fa++) begin
        clear_faults();
        scr_sa1[fa] = 8'h01 << ((fa + 5) % 8);
        run(3'b010, p, rom_sig());
      end
    // R9: two faults, lowest one reported.
    clear_faults();
    shr_sa1[9] = 8'h80; shr_sa1[4] = 8'h80;
    run(3'b001, 3, rom_sig());
    clear_faults();

    // R10: wrong signature fails.
    run(3'b100, 0, rom_sig() ^ 8'h10);
    run(3'b100, 1, rom_sig());

    // R4: start while busy ignored.
    @(negedge clk);
    tgt_sel = 3'b001; pat_sel = 2'd3; start = 1'b1; cnt_clr = 1'b1;
    @(negedge clk);
    start = 1'b0; cnt_clr = 1'b0;
    repeat (3) @(negedge clk);
    tgt_sel = 3'b111; pat_sel = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int w = 0;
      while (!done && w < 200) begin @(negedge clk); w++; end
    end
    check(pass == 3'b001, "R4 original targets kept", int'(pass), 1);
    check(scr_cnt == 0 && rom_cnt == 0, "R4 no late targets touched", scr_cnt + rom_cnt, 0);

    // R5: cancel mid-run.
    @(negedge clk);
    tgt_sel = 3'b111; pat_sel = 2'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    cancel = 1'b1;
    @(negedge clk);
    cancel = 1'b0; cnt_clr = 1'b1;
    check(!busy && !res_valid && !done, "R5 idle after cancel", int'({busy, res_valid, done}), 0);
    @(negedge clk);
    cnt_clr = 1'b0;
    begin
      int seen = 0;
      repeat (60) begin @(negedge clk); if (done) seen++; end
      check(seen == 0, "R5 no done after cancel", seen, 0);
    end
    check(shr_cnt + scr_cnt + rom_cnt == 0, "R5 strobes stopped", shr_cnt + scr_cnt + rom_cnt, 0);
    run(3'b111, 2, rom_sig());

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule